// File: doc/BRIEF.md
# Prioritized Interrupt Vector for a Serial Port

This block keeps the four interrupt flags of a serial port: transmission error, receive overrun, receive full and transmit empty. It encodes the most urgent pending flag as a 5-bit code and places that code inside a 32-bit read-only status word. The datapath raises the flags through single-cycle set pulses. A read strobe captures the status word. A write strobe on the transmit data register and a separate error-acknowledge pulse remove flags that a read leaves alone.

Reading the word has side effects. If the returned code names receive overrun or receive full, that flag drops at the end of the read cycle. The vector then moves on to the next pending source. The transmit-empty and error flags survive a read. An interrupt request output stays high while any source is pending.

Top module: `spi_irq_vector`

## Requirements
- R1: Priority from highest to lowest is transmission error, then receive overrun, then receive full, then transmit empty. The vector always names the highest pending flag, including when several flags rise in the same cycle.
- R2: The vector codes are 0x00 for nothing pending, 0x11 for error, 0x13 for receive overrun, 0x12 for receive full and 0x14 for transmit empty. No other code ever appears.
- R3: On a cycle with `rd_en` high, `rd_data` captures the status word at the clock edge and holds it until the next read. The vector sits in bits 5 to 1 of the word, and bits 31 to 6 and bit 0 are zero.
- R4: A set pulse makes its flag pending at the next clock edge. `vec` and `irq` follow the flags combinationally, with no further delay.
- R5: A read that returns 0x13 clears the receive-overrun flag, and a read that returns 0x12 clears the receive-full flag. The clear takes effect at the edge that ends the read cycle.
- R6: A read that returns 0x14 leaves the transmit-empty flag set. Only a `tx_wr` pulse clears it.
- R7: A read that returns 0x11 leaves the error flag set. Only an `err_ack` pulse clears it.
- R8: After a clearing read, `vec` shows the next highest pending source, or 0x00 when none is left.
- R9: When a set pulse and a clear (read, `tx_wr` or `err_ack`) hit the same flag in the same cycle, the flag stays pending.
- R10: `irq` is high exactly when `vec` is non-zero.
- R11: Synchronous reset clears every flag and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_err | input | 1 | Transmission error set pulse |
| set_ovr | input | 1 | Receive overrun set pulse |
| set_full | input | 1 | Receive full set pulse |
| set_txe | input | 1 | Transmit empty set pulse |
| rd_en | input | 1 | Status word read strobe |
| tx_wr | input | 1 | Transmit data register write strobe |
| err_ack | input | 1 | Error acknowledge pulse |
| rd_data | output | 32 | Captured status word |
| vec | output | 5 | Current vector code |
| irq | output | 1 | Interrupt request |

## Verification
The difficult coincidence is a flag's clear and its own set pulse landing in the same cycle. For receive full this is a clearing read that returns 0x12 together with `set_full`. For transmit empty it is `tx_wr` together with `set_txe`, and for the error flag it is `err_ack` together with `set_err`. Directed sequences drive each pair at once, and a long random phase repeats them freely. The bench judges the outcome against a behavioural flag model in which the set always survives. It also checks that the captured word still carries the code that was pending before the edge.

// File: rtl/spi_irq_vector_pkg.sv
package spi_irq_vector_pkg;
  localparam int NUM_SRC = 4;
  localparam int VEC_W   = 5;
  // source index order is priority order, index 0 highest
  localparam int SRC_ERR  = 0;
  localparam int SRC_OVR  = 1;
  localparam int SRC_FULL = 2;
  localparam int SRC_TXE  = 3;

  localparam logic [VEC_W-1:0] CODE_NONE = 5'h00;
  localparam logic [VEC_W-1:0] CODE_ERR  = 5'h11;
  localparam logic [VEC_W-1:0] CODE_FULL = 5'h12;
  localparam logic [VEC_W-1:0] CODE_OVR  = 5'h13;
  localparam logic [VEC_W-1:0] CODE_TXE  = 5'h14;

  function automatic logic [VEC_W-1:0] src_code(input int idx);
    case (idx)
      SRC_ERR:  return CODE_ERR;
      SRC_OVR:  return CODE_OVR;
      SRC_FULL: return CODE_FULL;
      SRC_TXE:  return CODE_TXE;
      default:  return CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ivr_flags.sv
module ivr_flags #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flags_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flags_o[i] <= 1'b0;
      else if (set_i[i]) flags_o[i] <= 1'b1;
      else if (clr_i[i]) flags_o[i] <= 1'b0;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flags_o[i]);

    // R6
    hold_unless_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
  end
endmodule

// File: rtl/ivr_prio.sv
module ivr_prio
  import spi_irq_vector_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]     flags_i,
  output logic [N-1:0]     grant_o,
  output logic [VEC_W-1:0] code_o
);
  assign grant_o[0] = flags_i[0];
  for (genvar i = 1; i < N; i++) begin : g_grant
    assign grant_o[i] = flags_i[i] & ~(|flags_i[i-1:0]);
  end

  always_comb begin
    code_o = CODE_NONE;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) code_o = code_o | src_code(i);
  end
endmodule

// File: rtl/spi_irq_vector.sv
module spi_irq_vector
  import spi_irq_vector_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int VEC_LSB = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_err,
  input  logic              set_ovr,
  input  logic              set_full,
  input  logic              set_txe,
  input  logic              rd_en,
  input  logic              tx_wr,
  input  logic              err_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [VEC_W-1:0]  vec,
  output logic              irq
);
  localparam int VEC_MSB = VEC_LSB + VEC_W - 1;

  logic [NUM_SRC-1:0] set_v, clr_v, flags, grant;
  logic [DATA_W-1:0]  word;

  assign set_v[SRC_ERR]  = set_err;
  assign set_v[SRC_OVR]  = set_ovr;
  assign set_v[SRC_FULL] = set_full;
  assign set_v[SRC_TXE]  = set_txe;

  // read side effects follow the code being returned in this cycle
  assign clr_v[SRC_ERR]  = err_ack;
  assign clr_v[SRC_OVR]  = rd_en && (vec == CODE_OVR);
  assign clr_v[SRC_FULL] = rd_en && (vec == CODE_FULL);
  assign clr_v[SRC_TXE]  = tx_wr;

  ivr_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .flags_o(flags)
  );

  ivr_prio #(.N(NUM_SRC)) u_prio (
    .flags_i(flags), .grant_o(grant), .code_o(vec)
  );

  always_comb begin
    word = '0;
    word[VEC_MSB:VEC_LSB] = vec;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= word;
  end

  assign irq = |flags;

  // R10
  irq_vec_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (vec != CODE_NONE));

  // R3
  rd_capture_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data[VEC_MSB:VEC_LSB] == $past(vec)) && (rd_data[0] == 1'b0));

  // R5
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && vec == CODE_OVR && !set_ovr) |=> !flags[SRC_OVR]);

  // R1
  err_top_chk: assert property (@(posedge clk) disable iff (rst)
    flags[SRC_ERR] |-> vec == CODE_ERR);

  // R7
  err_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[SRC_ERR] && rd_en && !err_ack) |=> vec == CODE_ERR);

  // R2
  grant_one_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: tb/sim_spi_irq_vector.sv
module sim_spi_irq_vector;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic set_err = 0, set_ovr = 0, set_full = 0, set_txe = 0;
  logic rd_en = 0, tx_wr = 0, err_ack = 0;
  logic [31:0] rd_data;
  logic [4:0]  vec;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  spi_irq_vector u0 (
    .clk(clk), .rst(rst), .set_err(set_err), .set_ovr(set_ovr),
    .set_full(set_full), .set_txe(set_txe), .rd_en(rd_en), .tx_wr(tx_wr),
    .err_ack(err_ack), .rd_data(rd_data), .vec(vec), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit m_err, m_ovr, m_full, m_txe;
  logic [31:0] m_rd;

  function automatic logic [4:0] m_vec();
    if (m_err)  return 5'h11;
    if (m_ovr)  return 5'h13;
    if (m_full) return 5'h12;
    if (m_txe)  return 5'h14;
    return 5'h00;
  endfunction

  always @(posedge clk) begin
    logic [4:0] v;
    v = m_vec();
    if (rst) begin
      m_err = 0; m_ovr = 0; m_full = 0; m_txe = 0; m_rd = 0;
    end else begin
      if (rd_en) m_rd = {26'd0, v, 1'b0};
      m_err  = set_err  | (m_err  & !err_ack);
      m_ovr  = set_ovr  | (m_ovr  & !(rd_en && v == 5'h13));
      m_full = set_full | (m_full & !(rd_en && v == 5'h12));
      m_txe  = set_txe  | (m_txe  & !tx_wr);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 vec", {27'd0, vec}, {27'd0, m_vec()});
      chk("R10 irq", {31'd0, irq}, {31'd0, (m_vec() != 5'h00)});
      chk("R3 rd_data", rd_data, m_rd);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    set_err = 0; set_ovr = 0; set_full = 0; set_txe = 0;
    rd_en = 0; tx_wr = 0; err_ack = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    chk("R11 vec after reset", {27'd0, vec}, 32'h0);
    chk("R11 rd_data after reset", rd_data, 32'h0);
    chk("R11 irq after reset", {31'd0, irq}, 32'h0);

    // three flags at once, then drain by reads
    set_ovr = 1; set_full = 1; set_txe = 1; tick(); idle();
    chk("R4 vec after set", {27'd0, vec}, 32'h13);
    rd_en = 1; tick(); idle();
    chk("R5 read overrun word", rd_data, 32'h26);
    chk("R8 next after overrun", {27'd0, vec}, 32'h12);
    rd_en = 1; tick(); idle();
    chk("R5 read full word", rd_data, 32'h24);
    chk("R8 next after full", {27'd0, vec}, 32'h14);
    rd_en = 1; tick(); idle();
    chk("R6 read txe word", rd_data, 32'h28);
    chk("R6 txe kept after read", {27'd0, vec}, 32'h14);
    tick();
    chk("R3 rd_data held", rd_data, 32'h28);
    tx_wr = 1; tick(); idle();
    chk("R6 txe cleared by write", {27'd0, vec}, 32'h0);
    chk("R10 irq low", {31'd0, irq}, 32'h0);

    // error flag above transmit empty
    set_err = 1; set_txe = 1; tick(); idle();
    chk("R2 error code", {27'd0, vec}, 32'h11);
    rd_en = 1; tick(); idle();
    chk("R7 read error word", rd_data, 32'h22);
    chk("R7 error kept after read", {27'd0, vec}, 32'h11);
    err_ack = 1; tick(); idle();
    chk("R7 error cleared by ack", {27'd0, vec}, 32'h14);
    tx_wr = 1; tick(); idle();

    // set wins over clear
    set_full = 1; tick(); idle();
    rd_en = 1; set_full = 1; tick(); idle();
    chk("R9 full read and set", {27'd0, vec}, 32'h12);
    chk("R9 word captured", rd_data, 32'h24);
    rd_en = 1; tick(); idle();
    set_txe = 1; tick(); idle();
    tx_wr = 1; set_txe = 1; tick(); idle();
    chk("R9 txe write and set", {27'd0, vec}, 32'h14);
    set_err = 1; tick(); idle();
    err_ack = 1; set_err = 1; tick(); idle();
    chk("R9 error ack and set", {27'd0, vec}, 32'h11);

    // random mix, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      set_err  = ($urandom_range(0, 15) == 0);
      set_ovr  = ($urandom_range(0, 5) == 0);
      set_full = ($urandom_range(0, 3) == 0);
      set_txe  = ($urandom_range(0, 3) == 0);
      rd_en    = ($urandom_range(0, 2) == 0);
      tx_wr    = ($urandom_range(0, 4) == 0);
      err_ack  = ($urandom_range(0, 6) == 0);
      if (i % 500 == 499) rst = 1'b1; else rst = 1'b0;
      tick();
    end
    idle(); rst = 1'b0;
    tick(); tick();
    finish_run();
  end
endmodule